// File: doc/BRIEF.md
# Fuse PROM Bit-Programming Sequencer

This block drives the digital control lines of a fuse-PROM programming fixture. The target device takes its programming-voltage pulse on a chip-enable pin. A programming session begins with a one-cycle `start` request that carries a word address and a mask of output bits to blow. The sequencer first turns on the raised-supply enable. It then visits the selected bits one at a time, from the lowest set bit upward. For each bit it raises the program-pin voltage enable, waits a lead guard time, and drives that single output's voltage enable for a fixed pulse width. It then holds the program-pin enable for a lag guard time before moving to the next bit. Bits that are clear in the mask receive no pulse.

After the last pulse the block drops every programming enable and drives both active-low chip enables low to read the word back. A blown fuse reads as logic 0. If any selected bit still reads 1, a reject flag is raised. `done` and `reject` stay valid until the next accepted start. The fixture's analog drivers and current-sink checks are outside this block. The address and mask are plain control inputs sampled on the start cycle, so there is no stream interface and no back-pressure.

Top module: `fprog_seq`

## Requirements
- R1: After reset, `busy`, `done` and `reject` are 0, `vcc_prog_en`, `vpp_en` and `vout_en` are all 0, and `ce1_n` and `ce2_n` are 1.
- R2: `vpp_en` is only ever high while `vcc_prog_en` is high, and `vcc_prog_en` is already high in the cycle before `vpp_en` rises.
- R3: Whenever `vpp_en` or any bit of `vout_en` is high, both `ce1_n` and `ce2_n` are 1 (chip disabled).
- R4: `vout_en` is non-zero only while `vpp_en` is high, and each output pulse begins exactly LEAD_CYC cycles after `vpp_en` rises.
- R5: Each output pulse holds `vout_en` non-zero for exactly PULSE_CYC consecutive cycles.
- R6: `vpp_en` stays high for exactly LAG_CYC cycles after `vout_en` returns to zero, then falls.
- R7: `vout_en` has at most one bit set. Bit i of `vout_en` drives mask bit i. Pulses occur once per set mask bit, in ascending bit order, and clear mask bits get no pulse.
- R8: After the last pulse, the block enters a verify phase with `ce1_n` = `ce2_n` = 0 and `vcc_prog_en`, `vpp_en` and `vout_en` all 0. `reject` becomes 1 exactly when some bit set in the mask reads back as 1 on `rd_data`. Read-back bits outside the mask are ignored.
- R9: A `start` pulse while `busy` is 1 is ignored. The session keeps its original address and mask.
- R10: `done` and `reject` hold their values while idle until the next `start`. A `start` in idle clears `done` in the following cycle.
- R11: An all-zero mask produces no programming pulse. The session goes straight to verify and finishes with `reject` = 0.
- R12: While `busy`, `addr_out` stays equal to the address sampled on the start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Session request, sampled when idle |
| addr_in | input | ADDR_W | Word address for the session |
| mask_in | input | DATA_W | Bits to blow, bit i = output i |
| rd_data | input | DATA_W | Logic levels read back from the device outputs |
| busy | output | 1 | Session in progress |
| done | output | 1 | Session finished; held until next start |
| reject | output | 1 | A selected bit failed to verify; held until next start |
| addr_out | output | ADDR_W | Address applied to the device |
| vcc_prog_en | output | 1 | Raised programming supply enable |
| vpp_en | output | 1 | Program-pin voltage enable |
| vout_en | output | DATA_W | Per-output voltage enable, one-hot or zero |
| ce1_n | output | 1 | Chip enable 1, active low |
| ce2_n | output | 1 | Chip enable 2, active low |

## Verification
The bound checker watches the electrical safety rules on every cycle. These are the chip disabled during pulses, supply before program-pin voltage, a one-hot output enable, and the exact lead, width and lag of each nested pulse, counted by small run-length counters. It also checks that `done` persists and that the address stays stable while busy. The bench alone can show the order in which bits are visited, that clear bits are skipped, that a start during a session is ignored, and that the reject decision reflects only the selected bits. For this it uses a fuse model that records the pulses it sees and can be told to leave chosen fuses intact.

// File: rtl/fprog_pkg.sv
package fprog_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RAISE,
    S_SELECT,
    S_LEAD,
    S_PULSE,
    S_LAG,
    S_VSET,
    S_VCHK
  } seq_state_t;
endpackage

// File: rtl/fprog_lowbit.sv
module fprog_lowbit #(
  parameter int W = 8
) (
  input  logic [W-1:0] vec,
  output logic         found,
  output logic [W-1:0] onehot
);
  // isolate lowest set bit: vec AND its two's complement
  assign onehot = vec & (~vec + W'(1));
  assign found  = |vec;
endmodule

// File: rtl/fprog_phase_timer.sv
module fprog_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (restart) count <= '0;
    else              count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/fprog_seq.sv
module fprog_seq
  import fprog_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int LEAD_CYC  = 2,
  parameter int PULSE_CYC = 4,
  parameter int LAG_CYC   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] mask_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              reject,
  output logic [ADDR_W-1:0] addr_out,
  output logic              vcc_prog_en,
  output logic              vpp_en,
  output logic [DATA_W-1:0] vout_en,
  output logic              ce1_n,
  output logic              ce2_n
);
  localparam int MAX_CYC = (LEAD_CYC > PULSE_CYC) ?
                           ((LEAD_CYC > LAG_CYC) ? LEAD_CYC : LAG_CYC) :
                           ((PULSE_CYC > LAG_CYC) ? PULSE_CYC : LAG_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  seq_state_t        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] sel_q;
  logic [DATA_W-1:0] pend_q;
  logic [DATA_W-1:0] cur_q;
  logic              done_q, reject_q;
  logic [CNT_W-1:0]  phase_cnt;
  logic              pick_found;
  logic [DATA_W-1:0] pick_bit;

  fprog_lowbit #(.W(DATA_W)) u_pick (
    .vec    (pend_q),
    .found  (pick_found),
    .onehot (pick_bit)
  );

  fprog_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (state_d != state_q),
    .count   (phase_cnt)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (start) state_d = S_RAISE;
      S_RAISE:  state_d = S_SELECT;
      S_SELECT: state_d = pick_found ? S_LEAD : S_VSET;
      S_LEAD:   if (phase_cnt == CNT_W'(LEAD_CYC - 1))  state_d = S_PULSE;
      S_PULSE:  if (phase_cnt == CNT_W'(PULSE_CYC - 1)) state_d = S_LAG;
      S_LAG:    if (phase_cnt == CNT_W'(LAG_CYC - 1))   state_d = S_SELECT;
      S_VSET:   state_d = S_VCHK;
      S_VCHK:   state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      addr_q   <= '0;
      sel_q    <= '0;
      pend_q   <= '0;
      cur_q    <= '0;
      done_q   <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      state_q <= state_d;
      case (state_q)
        S_IDLE: if (start) begin
          addr_q   <= addr_in;
          sel_q    <= mask_in;
          pend_q   <= mask_in;
          done_q   <= 1'b0;
          reject_q <= 1'b0;
        end
        S_SELECT: if (pick_found) begin
          cur_q  <= pick_bit;
          pend_q <= pend_q & ~pick_bit;
        end
        S_VCHK: begin
          reject_q <= |(sel_q & rd_data);
          done_q   <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    busy        = (state_q != S_IDLE);
    done        = done_q;
    reject      = reject_q;
    addr_out    = addr_q;
    vpp_en      = (state_q == S_LEAD) || (state_q == S_PULSE) || (state_q == S_LAG);
    vcc_prog_en = vpp_en || (state_q == S_RAISE) || (state_q == S_SELECT);
    vout_en     = (state_q == S_PULSE) ? cur_q : '0;
    ce1_n       = !((state_q == S_VSET) || (state_q == S_VCHK));
    ce2_n       = ce1_n;
  end
endmodule

// File: rtl/fprog_seq_chk.sv
module fprog_seq_chk #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int LEAD_CYC  = 2,
  parameter int PULSE_CYC = 4,
  parameter int LAG_CYC   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] addr_out,
  input logic              vcc_prog_en,
  input logic              vpp_en,
  input logic [DATA_W-1:0] vout_en,
  input logic              ce1_n,
  input logic              ce2_n
);
  localparam int CW = 16;
  logic [CW-1:0] lead_c, width_c, lag_c;
  logic          seen;
  logic          vout_on;
  assign vout_on = (vout_en != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_c <= '0; width_c <= '0; lag_c <= '0; seen <= 1'b0;
    end else begin
      if (!vpp_en) begin
        lead_c <= '0; lag_c <= '0; seen <= 1'b0;
      end else if (vout_on) begin
        seen <= 1'b1;
      end else if (!seen) begin
        lead_c <= lead_c + CW'(1);
      end else begin
        lag_c <= lag_c + CW'(1);
      end
      width_c <= vout_on ? width_c + CW'(1) : '0;
    end
  end

  // R2
  vcc_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_en |-> vcc_prog_en);
  // R2
  vcc_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vpp_en) |-> $past(vcc_prog_en));
  // R3
  ce_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_en || vout_on) |-> (ce1_n && ce2_n));
  // R4
  vout_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vout_on |-> vpp_en);
  // R4
  lead_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vout_on && !seen) |-> (lead_c == CW'(LEAD_CYC)));
  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vout_on && width_c != '0) |-> (width_c == CW'(PULSE_CYC)));
  // R5
  pulse_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vout_on |-> (width_c < CW'(PULSE_CYC)));
  // R6
  lag_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vpp_en) |-> (lag_c == CW'(LAG_CYC)));
  // R7
  one_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vout_en));
  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  // R12
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_out));
endmodule

bind fprog_seq fprog_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEAD_CYC(LEAD_CYC),
  .PULSE_CYC(PULSE_CYC), .LAG_CYC(LAG_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .addr_out(addr_out), .vcc_prog_en(vcc_prog_en), .vpp_en(vpp_en),
  .vout_en(vout_en), .ce1_n(ce1_n), .ce2_n(ce2_n)
);

// File: tb/fprog_seq_test.sv
module fprog_seq_test;
  localparam int AW = 10, DW = 8, TD1 = 2, TP = 4, TD2 = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] mask_in = '0, rd_data;
  logic busy, done, reject, vcc_prog_en, vpp_en, ce1_n, ce2_n;
  logic [AW-1:0] addr_out;
  logic [DW-1:0] vout_en;

  int n_tests = 0, n_fail = 0;
  logic [DW-1:0] stuck = '0, prog_seen = '0;
  int seq_idx[32];
  int seq_n = 0;

  always #4 clk = ~clk;

  // fuse model: blown fuses read 0 unless held intact by stuck
  assign rd_data = ~(prog_seen & ~stuck);

  fprog_seq #(.ADDR_W(AW), .DATA_W(DW), .LEAD_CYC(TD1), .PULSE_CYC(TP), .LAG_CYC(TD2)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in), .mask_in(mask_in),
    .rd_data(rd_data), .busy(busy), .done(done), .reject(reject), .addr_out(addr_out),
    .vcc_prog_en(vcc_prog_en), .vpp_en(vpp_en), .vout_en(vout_en), .ce1_n(ce1_n), .ce2_n(ce2_n));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // port monitor for pulse shape
  logic p_vpp = 1'b0, p_vcc = 1'b0, had_vout = 1'b0;
  logic [DW-1:0] p_vout = '0;
  int lead = 0, width = 0, lag = 0;
  always @(negedge clk) if (rst_n) begin
    if (vpp_en && !p_vpp) begin
      chk(p_vcc, "R2", "vcc before vpp", p_vcc, 1);
      lead = 0; lag = 0; had_vout = 1'b0;
    end
    if ((vpp_en || vout_en != 0) && !(ce1_n && ce2_n)) chk(0, "R3", "ce during pulse", ce1_n, 1);
    if (vout_en != 0 && !vpp_en) chk(0, "R4", "vout outside vpp", vpp_en, 1);
    if ($countones(vout_en) > 1) chk(0, "R7", "vout onehot", $countones(vout_en), 1);
    if (vout_en != 0 && p_vout == 0) begin
      chk(lead == TD1, "R4", "lead cycles", lead, TD1);
      for (int i = 0; i < DW; i++) if (vout_en[i]) begin
        seq_idx[seq_n] = i; if (seq_n < 31) seq_n++;
      end
      prog_seen = prog_seen | vout_en;
      width = 0; had_vout = 1'b1;
    end
    if (vout_en == 0 && p_vout != 0) chk(width == TP, "R5", "pulse width", width, TP);
    if (!vpp_en && p_vpp) chk(lag == TD2, "R6", "lag cycles", lag, TD2);
    if (vpp_en && vout_en == 0 && !had_vout) lead++;
    if (vout_en != 0) width++;
    if (vpp_en && vout_en == 0 && had_vout) lag++;
    p_vpp = vpp_en; p_vcc = vcc_prog_en; p_vout = vout_en;
  end

  task automatic run_session(input logic [AW-1:0] a, input logic [DW-1:0] m,
                             input logic [DW-1:0] s, input bit intrude);
    bit addr_ok = 1'b1, ver_ok = 1'b1, ver_seen = 1'b0;
    int guard = 0, k = 0;
    @(negedge clk);
    stuck = s; prog_seen = '0; seq_n = 0;
    addr_in = a; mask_in = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R10", "start clears done", done, 0);
    while (!done && guard < 5000) begin
      if (intrude && guard == 3) begin
        start = 1'b1; addr_in = ~a; mask_in = ~m;
      end else if (intrude && guard == 4) begin
        start = 1'b0; addr_in = a; mask_in = m;
      end
      if (busy && addr_out != a) addr_ok = 1'b0;
      if (!ce1_n || !ce2_n) begin
        ver_seen = 1'b1;
        if (ce1_n || ce2_n || vcc_prog_en || vpp_en || vout_en != 0) ver_ok = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    chk(done, "R8", "session finished", done, 1);
    chk(addr_ok, "R12", "addr_out held", addr_out, a);
    chk(ver_seen && ver_ok, "R8", "verify phase levels", ver_ok, 1);
    chk(reject == |(m & s), "R8", "reject flag", reject, |(m & s));
    chk(seq_n == $countones(m), intrude ? "R9" : "R7", "pulse count", seq_n, $countones(m));
    for (int i = 0; i < DW; i++) if (m[i]) begin
      chk(k < seq_n && seq_idx[k] == i, "R7", "pulse order", seq_idx[k], i);
      k++;
    end
  endtask

  task automatic t_reset;
    chk(!busy && !done && !reject, "R1", "status at reset", {busy, done, reject}, 0);
    chk(!vcc_prog_en && !vpp_en && vout_en == 0, "R1", "enables at reset", vout_en, 0);
    chk(ce1_n && ce2_n, "R1", "chip enables at reset", {ce1_n, ce2_n}, 3);
  endtask

  task automatic t_hold;
    logic r;
    run_session(10'h155, 8'h40, 8'h40, 1'b0);
    r = reject;
    repeat (6) @(negedge clk);
    chk(done && reject == r, "R10", "done and reject held", {done, reject}, {1'b1, r});
    chk(!busy && vout_en == 0 && ce1_n, "R10", "idle outputs after done", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_session(10'h2A5, 8'b1010_0101, 8'h00, 1'b0);  // R7 mixed mask, all blow
    run_session(10'h3FF, 8'h80, 8'h80, 1'b0);         // R8 msb intact -> reject
    run_session(10'h001, 8'h00, 8'hFF, 1'b0);         // R11 empty mask
    chk(seq_n == 0 && !reject, "R11", "empty mask result", seq_n, 0);
    run_session(10'h0C3, 8'h0F, 8'hF0, 1'b0);         // R8 unselected intact ignored
    run_session(10'h111, 8'h12, 8'h00, 1'b1);         // R9 start during session
    t_hold();                                         // R10
    run_session(10'h200, 8'hFF, 8'h00, 1'b0);         // R5 every bit
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule